// File: doc/BRIEF.md
# Table-Driven Time Slot Assigner

This block steps one direction of a time-division serial line through a table of 16-bit slot descriptors. Each descriptor names the channel controller that owns the slot, a four-bit pattern for the strobe pins, the slot length, and whether it closes the frame. An upstream frame-sync front end supplies a single-cycle `bit_tick` for every bit time and raises `frame_sync` together with the tick on the first bit of a frame. For every bit the assigner raises one bit strobe toward the owning channel. On transmit it multiplexes that channel's data onto the line. On receive it passes the line data out and uses the strobe to say which channel takes the bit.

The table is written through a plain address/data write port and can be changed between frames. The parameter `RX_SIDE` picks the receive variant, in which the pin-role swap bit takes effect. The controller has three states. `ST_IDLE` waits for a sync tick. `ST_SLOT` runs the descriptors. `ST_FAULT` is entered when the last table entry ends without closing the frame. The transitions are:
- IDLE→SLOT and FAULT→SLOT on a sync tick.
- SLOT→SLOT when the next descriptor is loaded or a sync restarts the frame.
- SLOT→IDLE when a closing slot ends.
- SLOT→FAULT when the table is exhausted.

Descriptor layout, with bit 15 as the most significant bit:

| Bits | Field |
|------|-------|
| [15] | multichannel format, ignored |
| [14] | pin-role swap |
| [13:10] | strobe pattern |
| [9] | reserved |
| [8:5] | channel code |
| [4:2] | count |
| [1] | unit select |
| [0] | closing flag |

Top module: `slot_assigner`

## Requirements
- R1: After reset the block is idle: `slot_active`=0, `chan_stb`=0, `pin_strobe`=0, `pin_swap`=0, `frame_err`=0, `chan_rxd`=0 and `line_txd`=1.
- R2: A tick with `frame_sync` high loads entry 0, so its slot owns the bit that starts with that tick, whatever state the block was in.
- R3: The channel code in bits [8:5] raises `chan_stb[code]` for codes 1 to 6 and 9 to 11. Codes 0, 7, 8 and 12 to 15 raise no strobe. At most one strobe is ever high.
- R4: A slot lasts count+1 bit times when bit [1]=0, and 8×(count+1) bit times when bit [1]=1. Outputs change only after a tick.
- R5: `pin_strobe` equals bits [13:10] of the current entry for the whole slot, and is 0 while not active.
- R6: A closing flag (bit [0]) in an odd-numbered entry ends the frame. Once that slot expires the block idles until the next sync tick, which restarts at entry 0.
- R7: A closing flag in an even-numbered entry has no effect, and the next entry follows.
- R8: A slot with no strobe (null slot) drives `line_txd` high on transmit. On receive it discards data, with `chan_rxd` held at 0.
- R9: On transmit, `line_txd` equals `chan_txd[code]` during a slot that has a strobe.
- R10: On receive, `chan_rxd` follows `line_rxd` during a slot that has a strobe.
- R11: Bit [14] drives `pin_swap` for the slot on the receive variant. The transmit variant ignores it and keeps `pin_swap` at 0.
- R12: If the last table entry (index TBL_DEPTH-1) expires without closing the frame, the block raises `frame_err` and stops. `frame_err` stays high until the next sync tick clears it.
- R13: Bit [15] is ignored: an entry with it set behaves like the same entry with it clear.
- R14: An entry written through the table port between frames is used the next time that entry is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | AW (8) | Table write index |
| tbl_wdata | input | 16 | Descriptor to write |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| frame_sync | input | 1 | Frame start, qualified by bit_tick |
| chan_txd | input | 16 | Transmit data per channel code |
| line_rxd | input | 1 | Serial line receive data |
| line_txd | output | 1 | Serial line transmit data |
| chan_rxd | output | 1 | Receive data toward channels |
| chan_stb | output | 16 | Per-channel bit strobe, indexed by code |
| pin_strobe | output | 4 | Slot strobe pins |
| pin_swap | output | 1 | Pin-role swap for current slot |
| slot_active | output | 1 | Sequencer is inside a frame |
| frame_err | output | 1 | Table ran out without a closing flag |

## Verification
The assertions assume the following about the inputs:
- `bit_tick` is a single-cycle pulse.
- `frame_sync` only matters in a tick cycle.
- The line inputs and `chan_txd` are steady data, so that output stability between ticks is a property of the block alone.

The stimulus raises each tick for exactly one cycle, with at least one quiet cycle between ticks. It writes the table only between frames, and it changes channel data only between bit times.

// File: rtl/tsa_pkg.sv
package tsa_pkg;

    // Slot descriptor, most significant field first
    typedef struct packed {
        logic       mc;       // multichannel format flag (not handled)
        logic       swap;     // swap line roles (receive side only)
        logic [3:0] stb;      // strobe pin pattern
        logic       rsvd;
        logic [3:0] chan;     // channel code
        logic [2:0] cnt;      // length minus one
        logic       byte_u;   // 1: length counted in bytes
        logic       last;     // closes the frame (odd entry only)
    } tsa_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SLOT  = 2'd1,
        ST_FAULT = 2'd2
    } tsa_state_t;

    localparam int CODE_W   = 4;
    localparam int NUM_CODE = 1 << CODE_W;
    localparam int LEN_W    = 6;

    function automatic logic code_routed(input logic [CODE_W-1:0] code);
        unique case (code)
            4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6,
            4'd9, 4'd10, 4'd11: code_routed = 1'b1;
            default:            code_routed = 1'b0;
        endcase
    endfunction

    // slot length in bit times, minus one
    function automatic logic [LEN_W-1:0] slot_len_m1(input tsa_entry_t e);
        if (e.byte_u)
            slot_len_m1 = {e.cnt, 3'b111};
        else
            slot_len_m1 = {3'b000, e.cnt};
    endfunction

endpackage

// File: rtl/tsa_table.sv
module tsa_table #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  tsa_pkg::tsa_entry_t      wdata,
    input  logic [AW-1:0]            raddr,
    output tsa_pkg::tsa_entry_t      rdata
);
    tsa_pkg::tsa_entry_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/tsa_seq.sv
module tsa_seq #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bit_tick,
    input  logic                     frame_sync,
    input  tsa_pkg::tsa_entry_t      rd_data,
    output logic [AW-1:0]            rd_addr,
    output tsa_pkg::tsa_entry_t      cur,
    output logic                     active,
    output logic                     fault
);
    import tsa_pkg::*;

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    tsa_state_t       state, state_nxt;
    logic [AW-1:0]    ptr;
    logic [LEN_W-1:0] remain;

    logic sync_tick, slot_done, closes, exhausted, load;

    // bits of the descriptor this block does not act on
    logic unused_fields;
    assign unused_fields = rd_data.mc ^ rd_data.rsvd;

    assign sync_tick = bit_tick && frame_sync;
    assign slot_done = bit_tick && (state == ST_SLOT) && (remain == '0);
    assign closes    = cur.last && ptr[0];
    assign exhausted = (ptr == LAST_IDX);
    assign load      = sync_tick || (slot_done && !closes && !exhausted);
    assign rd_addr   = sync_tick ? '0 : ptr + 1'b1;

    // next-state decision
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE, ST_FAULT: begin
                if (sync_tick) state_nxt = ST_SLOT;
            end
            ST_SLOT: begin
                if (sync_tick)      state_nxt = ST_SLOT;
                else if (slot_done) begin
                    if (closes)         state_nxt = ST_IDLE;
                    else if (exhausted) state_nxt = ST_FAULT;
                    else                state_nxt = ST_SLOT;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // slot pointer, length counter and current descriptor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr    <= '0;
            remain <= '0;
            cur    <= '0;
        end else if (load) begin
            ptr    <= rd_addr;
            remain <= slot_len_m1(rd_data);
            cur    <= rd_data;
        end else if (slot_done) begin
            cur    <= '0;
        end else if (bit_tick && state == ST_SLOT) begin
            remain <= remain - 1'b1;
        end
    end

    // outputs of the controller
    always_comb begin
        active = 1'b0;
        fault  = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_SLOT:  active = 1'b1;
            ST_FAULT: fault  = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/tsa_route.sv
module tsa_route #(
    parameter bit RX_SIDE = 1'b0
) (
    input  tsa_pkg::tsa_entry_t             cur,
    input  logic                            active,
    input  logic [tsa_pkg::NUM_CODE-1:0]    chan_txd,
    input  logic                            line_rxd,
    output logic [tsa_pkg::NUM_CODE-1:0]    chan_stb,
    output logic [3:0]                      pin_strobe,
    output logic                            pin_swap,
    output logic                            line_txd,
    output logic                            chan_rxd
);
    import tsa_pkg::*;

    logic routed;
    assign routed     = active && code_routed(cur.chan);
    assign pin_strobe = active ? cur.stb : 4'b0000;

    for (genvar g = 0; g < NUM_CODE; g++) begin : g_stb
        assign chan_stb[g] = routed && (cur.chan == CODE_W'(g));
    end

    if (RX_SIDE) begin : g_rx
        logic unused_tx;
        assign unused_tx = ^chan_txd;
        assign line_txd  = 1'b1;
        assign chan_rxd  = routed ? line_rxd : 1'b0;
        assign pin_swap  = active && cur.swap;
    end else begin : g_tx
        logic unused_rx;
        assign unused_rx = line_rxd ^ cur.swap;
        assign line_txd  = routed ? chan_txd[cur.chan] : 1'b1;
        assign chan_rxd  = 1'b0;
        assign pin_swap  = 1'b0;
    end

endmodule

// File: rtl/slot_assigner.sv
module slot_assigner #(
    parameter bit RX_SIDE   = 1'b0,
    parameter int TBL_DEPTH = 256,
    localparam int AW       = $clog2(TBL_DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tbl_we,
    input  logic [AW-1:0] tbl_addr,
    input  logic [15:0]   tbl_wdata,
    input  logic          bit_tick,
    input  logic          frame_sync,
    input  logic [15:0]   chan_txd,
    input  logic          line_rxd,
    output logic          line_txd,
    output logic          chan_rxd,
    output logic [15:0]   chan_stb,
    output logic [3:0]    pin_strobe,
    output logic          pin_swap,
    output logic          slot_active,
    output logic          frame_err
);
    import tsa_pkg::*;

    tsa_entry_t    rd_data, cur;
    logic [AW-1:0] rd_addr;

    tsa_table #(.DEPTH(TBL_DEPTH), .AW(AW)) u_table (
        .clk   (clk),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wdata (tsa_entry_t'(tbl_wdata)),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    tsa_seq #(.DEPTH(TBL_DEPTH), .AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .frame_sync (frame_sync),
        .rd_data    (rd_data),
        .rd_addr    (rd_addr),
        .cur        (cur),
        .active     (slot_active),
        .fault      (frame_err)
    );

    tsa_route #(.RX_SIDE(RX_SIDE)) u_route (
        .cur        (cur),
        .active     (slot_active),
        .chan_txd   (chan_txd),
        .line_rxd   (line_rxd),
        .chan_stb   (chan_stb),
        .pin_strobe (pin_strobe),
        .pin_swap   (pin_swap),
        .line_txd   (line_txd),
        .chan_rxd   (chan_rxd)
    );

endmodule

// File: rtl/slot_assigner_chk.sv
module slot_assigner_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bit_tick,
    input logic        frame_sync,
    input logic        line_txd,
    input logic        chan_rxd,
    input logic [15:0] chan_stb,
    input logic [3:0]  pin_strobe,
    input logic        pin_swap,
    input logic        slot_active,
    input logic        frame_err
);
    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_stb)); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_active |-> (chan_stb == 16'h0 && pin_strobe == 4'h0)); // R5
    AST_NULL_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_stb == 16'h0) |-> line_txd); // R8
    AST_NULL_RX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_stb == 16'h0) |-> !chan_rxd); // R8
    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_tick) |-> ($stable(chan_stb) && $stable(pin_strobe) && $stable(pin_swap))); // R4
    AST_SYNC_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && frame_sync) |=> (slot_active && !frame_err)); // R2
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> !slot_active); // R12
    AST_ERR_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err) |-> $past(bit_tick)); // R12
endmodule

bind slot_assigner slot_assigner_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_tick    (bit_tick),
    .frame_sync  (frame_sync),
    .line_txd    (line_txd),
    .chan_rxd    (chan_rxd),
    .chan_stb    (chan_stb),
    .pin_strobe  (pin_strobe),
    .pin_swap    (pin_swap),
    .slot_active (slot_active),
    .frame_err   (frame_err)
);

// File: tb/tb_slot_assigner.sv
`timescale 1ns/1ps
module tb_slot_assigner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0;
    logic [7:0]  tbl_addr = '0;
    logic [15:0] tbl_wdata = '0;
    logic        bit_tick = 1'b0;
    logic        frame_sync = 1'b0;
    logic [15:0] chan_txd = '0;
    logic        line_rxd = 1'b0;

    logic        t_line, t_rxd, t_swap, t_act, t_err;
    logic [15:0] t_stb;
    logic [3:0]  t_pst;
    logic        r_line, r_rxd, r_swap, r_act, r_err;
    logic [15:0] r_stb;
    logic [3:0]  r_pst;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    slot_assigner #(.RX_SIDE(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_wdata(tbl_wdata), .bit_tick(bit_tick), .frame_sync(frame_sync),
        .chan_txd(chan_txd), .line_rxd(line_rxd), .line_txd(t_line),
        .chan_rxd(t_rxd), .chan_stb(t_stb), .pin_strobe(t_pst),
        .pin_swap(t_swap), .slot_active(t_act), .frame_err(t_err));

    slot_assigner #(.RX_SIDE(1'b1)) dut_rx (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_wdata(tbl_wdata), .bit_tick(bit_tick), .frame_sync(frame_sync),
        .chan_txd(chan_txd), .line_rxd(line_rxd), .line_txd(r_line),
        .chan_rxd(r_rxd), .chan_stb(r_stb), .pin_strobe(r_pst),
        .pin_swap(r_swap), .slot_active(r_act), .frame_err(r_err));

    function automatic logic [15:0] mk(input logic mc, input logic sw,
                                       input logic [3:0] stb, input logic [3:0] ch,
                                       input logic [2:0] cnt, input logic byt,
                                       input logic last);
        return {mc, sw, stb, 1'b0, ch, cnt, byt, last};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [15:0] val);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = 8'(idx); tbl_wdata = val;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // one bit time; outputs are sampled after the tick has been taken
    task automatic step(input logic s);
        @(negedge clk);
        bit_tick = 1'b1; frame_sync = s;
        @(negedge clk);
        bit_tick = 1'b0; frame_sync = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 active", {31'b0, t_act}, 0);
        check("R1 stb", {16'b0, t_stb}, 0);
        check("R1 pins", {28'b0, t_pst}, 0);
        check("R1 line", {31'b0, t_line}, 1);
        check("R1 err/swap/rxd", {29'b0, t_err, t_swap, r_rxd}, 0);
    endtask

    task automatic t_basic_frame;
        wr(0, mk(0, 1, 4'b1000, 4'd2, 3'd2, 0, 0));
        wr(1, mk(1, 0, 4'b0001, 4'd9, 3'd0, 1, 1));
        chan_txd = 16'h0004;
        for (int b = 0; b < 11; b++) begin
            step(b == 0);
            if (b < 3) begin
                check("R2 R4 slot0 stb", {16'b0, t_stb}, 32'h0004);
                check("R5 slot0 pins", {28'b0, t_pst}, 8);
                check("R9 slot0 line", {31'b0, t_line}, 1);
                check("R11 tx swap", {31'b0, t_swap}, 0);
            end else begin
                check("R4 R13 slot1 stb", {16'b0, t_stb}, 32'h0200);
                check("R5 slot1 pins", {28'b0, t_pst}, 1);
                check("R9 slot1 line", {31'b0, t_line}, 0);
            end
        end
        step(0);
        check("R6 idle after close", {15'b0, t_act, t_stb}, 0);
        check("R6 idle line", {31'b0, t_line}, 1);
        step(0);
        check("R6 stays idle", {31'b0, t_act}, 0);
        step(1);
        check("R6 restart entry0", {16'b0, t_stb}, 32'h0004);
    endtask

    task automatic t_resync;
        // continue the frame started at the end of t_basic_frame
        for (int b = 0; b < 4; b++) step(0);
        check("R13 mid slot1", {16'b0, t_stb}, 32'h0200);
        step(1);
        check("R2 resync entry0", {16'b0, t_stb}, 32'h0004);
        step(0); step(0);
        check("R4 third bit slot0", {16'b0, t_stb}, 32'h0004);
        step(0);
        check("R4 fourth bit slot1", {16'b0, t_stb}, 32'h0200);
        for (int b = 0; b < 8; b++) step(0);
    endtask

    task automatic t_null_even;
        wr(0, mk(0, 0, 4'b0101, 4'd0, 3'd0, 0, 1));
        wr(1, mk(0, 0, 4'b0000, 4'd7, 3'd0, 0, 0));
        wr(2, mk(0, 0, 4'b0000, 4'd11, 3'd1, 0, 0));
        wr(3, mk(0, 0, 4'b0000, 4'd1, 3'd0, 0, 1));
        chan_txd = 16'h0000;
        step(1);
        check("R8 null stb", {16'b0, t_stb}, 0);
        check("R8 null line high", {31'b0, t_line}, 1);
        check("R5 null pins", {28'b0, t_pst}, 5);
        step(0);
        check("R7 even last ignored", {31'b0, t_act}, 1);
        check("R3 code7 unrouted", {16'b0, t_stb}, 0);
        step(0);
        check("R3 code11", {16'b0, t_stb}, 32'h0800);
        check("R9 line low", {31'b0, t_line}, 0);
        step(0);
        check("R4 code11 second bit", {16'b0, t_stb}, 32'h0800);
        step(0);
        check("R3 code1", {16'b0, t_stb}, 32'h0002);
        step(0);
        check("R6 closed at entry3", {31'b0, t_act}, 0);
    endtask

    task automatic t_exhaust;
        for (int i = 0; i < 256; i++) wr(i, mk(0, 0, 4'b0000, 4'd3, 3'd0, 0, 0));
        step(1);
        for (int i = 1; i < 256; i++) step(0);
        check("R12 last entry running", {30'b0, t_act, t_err}, 2);
        check("R12 last entry stb", {16'b0, t_stb}, 32'h0008);
        step(0);
        check("R12 fault raised", {30'b0, t_act, t_err}, 1);
        step(0);
        check("R12 fault held", {31'b0, t_err}, 1);
        step(1);
        check("R12 sync clears", {30'b0, t_act, t_err}, 2);
        for (int i = 0; i < 257; i++) step(0);
    endtask

    task automatic t_receive;
        wr(0, mk(0, 1, 4'b0010, 4'd4, 3'd1, 0, 0));
        wr(1, mk(0, 0, 4'b0000, 4'd6, 3'd0, 0, 1));
        line_rxd = 1'b1;
        step(1);
        check("R14 R3 rx stb", {16'b0, r_stb}, 32'h0010);
        check("R11 rx swap", {31'b0, r_swap}, 1);
        check("R11 tx ignores swap", {31'b0, t_swap}, 0);
        check("R10 rxd high", {31'b0, r_rxd}, 1);
        line_rxd = 1'b0;
        #1;
        check("R10 rxd follows", {31'b0, r_rxd}, 0);
        step(0);
        line_rxd = 1'b1;
        step(0);
        check("R3 rx code6", {16'b0, r_stb}, 32'h0040);
        check("R11 swap off", {31'b0, r_swap}, 0);
        check("R10 rxd slot1", {31'b0, r_rxd}, 1);
        step(0);
        check("R6 rx idle", {15'b0, r_act, r_stb}, 0);
        check("R8 rx idle rxd", {31'b0, r_rxd}, 0);
        wr(0, mk(0, 0, 4'b0000, 4'd0, 3'd0, 0, 0));
        wr(1, mk(0, 0, 4'b0000, 4'd5, 3'd0, 0, 1));
        step(1);
        check("R8 rx null discards", {30'b0, r_act, r_rxd}, 2);
        step(0);
        check("R14 rx rewritten entry1", {16'b0, r_stb}, 32'h0020);
        check("R10 rxd code5", {31'b0, r_rxd}, 1);
        step(0);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_frame();
        t_resync();
        t_null_even();
        t_exhaust();
        t_receive();
        finish_run();
    end
endmodule